// File: doc/BRIEF.md
# Two-level nanocoded control store

The block sequences a microprogram through two tables. A narrow microcode table, addressed by a micro-program counter, holds 17-bit words. Each word is one of two kinds. A branch word carries a 10-bit target address. An issue word carries a 9-bit index into a second, wide table of 68-bit nanowords. The selected nanoword is expanded into 196 control lines. A control pattern that many micro-steps need is stored once in the nanoword table. Each step that needs it only names its index, so the microcode table stays narrow.

Each clock the block reads the word at the current micro-program counter. An issue word drives the decoded control lines and a valid strobe from the next edge, and the counter advances by one. A branch word drives no control lines and loads its target into the counter. When its condition bit is set, the target is loaded only if the condition flag is high in that cycle. Both tables are initialised constants computed at elaboration. The datapath that consumes the control lines is outside this block.

Top module: `nano_ctrl_store`

## Requirements
- R1: While reset is high, valid_o is 0 and ctrl_o is all zero from the first clock edge onward. The first word read after reset is the one at micro address 0.
- R2: Microcode word format: bit 16 = 1 marks a branch word, with bit 15 as its condition-enable bit and bits 9:0 as its target. Bit 16 = 0 marks an issue word, with bits 8:0 as its nanoword index.
- R3: An issue word makes valid_o 1 and ctrl_o the decoded nanoword from the next clock edge, and the micro address advances by one (wrapping at 10 bits).
- R4: A branch word makes valid_o 0 and ctrl_o all zero from the next clock edge.
- R5: A branch word with bit 15 clear always loads its target, whatever cond_i is.
- R6: A branch word with bit 15 set loads its target when cond_i is 1 in its cycle; otherwise the micro address advances by one.
- R7: cond_i has no effect while an issue word is being read.
- R8: Nanoword decode: eight 4-bit fields at bits 4g+3:4g drive ctrl_o[15g+code-1]. Ten 3-bit fields at bits 32+3h+2:32+3h drive ctrl_o[120+7h+code-1]. Code 0 drives no line, so each group is at most one-hot. Nanoword bits 67:62 drive ctrl_o[195:190] directly.
- R9: Two micro-steps that name the same nanoword index produce identical ctrl_o.
- R10: A nanoword index at or above the nanoword table depth (16) yields ctrl_o all zero, with valid_o still 1.
- R11: A micro address at or above the microcode table depth (32) reads as an unconditional branch to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cond_i | input | 1 | Condition flag tested by conditional branch words |
| ctrl_o | output | 196 | Decoded control lines |
| valid_o | output | 1 | High in cycles where ctrl_o comes from an issue word |

## Verification
The condition flag and a word's own kind meet in a single cycle. The flag is decisive when the word is a conditional branch and meaningless when it is an issue word or an unconditional branch. The stimulus table raises cond_i on a conditional branch, on issue words and on an unconditional branch, and holds it low on the same conditional branch in another pass. In each case the next valid_o, ctrl_o and the following issued nanoword are compared with the program's expected path. Redirection from an out-of-range micro address also falls on a branch cycle. It is judged by the zero control vector followed by the nanoword at address 0.

// File: rtl/nano_cs_pkg.sv
package nano_cs_pkg;
    localparam int UAW    = 10;
    localparam int NPW    = 9;
    localparam int UWW    = 17;
    localparam int F4     = 4;
    localparam int F3     = 3;
    localparam int NG4    = 8;
    localparam int NG3    = 10;
    localparam int ND     = 6;
    localparam int UDEPTH = 32;
    localparam int NDEPTH = 16;

    localparam int S4      = (1 << F4) - 1;
    localparam int S3      = (1 << F3) - 1;
    localparam int G3_BASE = NG4 * F4;
    localparam int DIR_BASE = G3_BASE + NG3 * F3;
    localparam int NWW     = DIR_BASE + ND;
    localparam int S3_BASE = NG4 * S4;
    localparam int SD_BASE = S3_BASE + NG3 * S3;
    localparam int NSIG    = SD_BASE + ND;
    localparam int KIND_BIT = UWW - 1;
    localparam int COND_BIT = UWW - 2;

    typedef logic [UWW-1:0]  uword_t;
    typedef logic [NWW-1:0]  nword_t;
    typedef logic [NSIG-1:0] ctrl_t;

    typedef struct packed {
        logic [UAW-1:0] upc;
        logic           valid;
        ctrl_t          ctrl;
    } seq_t;

    function automatic uword_t mk_jump(logic c, logic [UAW-1:0] t);
        uword_t w;
        w = '0;
        w[KIND_BIT] = 1'b1;
        w[COND_BIT] = c;
        w[UAW-1:0]  = t;
        return w;
    endfunction

    function automatic uword_t mk_issue(logic [NPW-1:0] p);
        uword_t w;
        w = '0;
        w[NPW-1:0] = p;
        return w;
    endfunction

    // Microprogram contents
    function automatic uword_t micro_word(int a);
        case (a)
            0:       return mk_issue(9'd1);
            1:       return mk_issue(9'd2);
            2:       return mk_issue(9'd1);
            3:       return mk_jump(1'b1, 10'd6);
            4:       return mk_issue(9'd3);
            5:       return mk_jump(1'b0, 10'd0);
            6:       return mk_issue(9'd4);
            7:       return mk_issue(9'd20);
            8:       return mk_jump(1'b0, 10'd40);
            default: return mk_jump(1'b0, 10'd0);
        endcase
    endfunction

    // Nanoword contents, computed per index
    function automatic nword_t nano_word(int idx);
        nword_t w;
        w = '0;
        for (int g = 0; g < NG4; g++) w[g*F4 +: F4] = F4'(idx + g);
        for (int h = 0; h < NG3; h++) w[G3_BASE + h*F3 +: F3] = F3'(idx*3 + h);
        w[DIR_BASE +: ND] = ND'(idx*5 + 1);
        return w;
    endfunction
endpackage

// File: rtl/nano_cs_urom.sv
module nano_cs_urom
    import nano_cs_pkg::*;
#(
    parameter int DEPTH = UDEPTH
) (
    input  logic [UAW-1:0] addr_i,
    output uword_t         word_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    uword_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign mem[i] = micro_word(i);
    end

    always_comb begin
        if (int'(addr_i) < DEPTH) word_o = mem[addr_i[IW-1:0]];
        else                      word_o = mk_jump(1'b0, '0);
    end
endmodule

// File: rtl/nano_cs_nrom.sv
module nano_cs_nrom
    import nano_cs_pkg::*;
#(
    parameter int DEPTH = NDEPTH
) (
    input  logic [NPW-1:0] ptr_i,
    output nword_t         word_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    nword_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign mem[i] = nano_word(i);
    end

    always_comb begin
        if (int'(ptr_i) < DEPTH) word_o = mem[ptr_i[IW-1:0]];
        else                     word_o = '0;
    end
endmodule

// File: rtl/nano_cs_decode.sv
module nano_cs_decode
    import nano_cs_pkg::*;
(
    input  nword_t nword_i,
    output ctrl_t  ctrl_o
);
    for (genvar g = 0; g < NG4; g++) begin : g_wide
        for (genvar k = 1; k <= S4; k++) begin : g_line
            assign ctrl_o[g*S4 + k - 1] = (nword_i[g*F4 +: F4] == F4'(k));
        end
    end

    for (genvar h = 0; h < NG3; h++) begin : g_narrow
        for (genvar k = 1; k <= S3; k++) begin : g_line
            assign ctrl_o[S3_BASE + h*S3 + k - 1] =
                (nword_i[G3_BASE + h*F3 +: F3] == F3'(k));
        end
    end

    assign ctrl_o[SD_BASE +: ND] = nword_i[DIR_BASE +: ND];
endmodule

// File: rtl/nano_ctrl_store.sv
module nano_ctrl_store
    import nano_cs_pkg::*;
#(
    parameter int UDEPTH_P = UDEPTH,
    parameter int NDEPTH_P = NDEPTH
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            cond_i,
    output logic [NSIG-1:0] ctrl_o,
    output logic            valid_o
);
    uword_t uword;
    nword_t nword;
    ctrl_t  dec;
    seq_t   state_d, state_q;
    logic   is_jump, take;
    logic [COND_BIT-UAW-1:0] rsvd_unused;

    assign rsvd_unused = uword[COND_BIT-1:UAW];

    nano_cs_urom #(.DEPTH(UDEPTH_P)) urom_i (
        .addr_i (state_q.upc),
        .word_o (uword)
    );

    nano_cs_nrom #(.DEPTH(NDEPTH_P)) nrom_i (
        .ptr_i  (uword[NPW-1:0]),
        .word_o (nword)
    );

    nano_cs_decode dec_i (
        .nword_i (nword),
        .ctrl_o  (dec)
    );

    always_comb begin
        state_d = state_q;
        is_jump = uword[KIND_BIT];
        take    = is_jump && (!uword[COND_BIT] || cond_i);
        if (is_jump) begin
            state_d.valid = 1'b0;
            state_d.ctrl  = '0;
            state_d.upc   = take ? uword[UAW-1:0] : state_q.upc + 1'b1;
        end else begin
            state_d.valid = 1'b1;
            state_d.ctrl  = dec;
            state_d.upc   = state_q.upc + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign ctrl_o  = state_q.ctrl;
    assign valid_o = state_q.valid;
endmodule

// File: rtl/nano_ctrl_store_chk.sv
module nano_ctrl_store_chk
    import nano_cs_pkg::*;
#(
    parameter int UDEPTH_P = UDEPTH
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            valid_o,
    input logic [NSIG-1:0] ctrl_o,
    input logic [UAW-1:0]  upc_i
);
    logic was_rst_q;

    always_ff @(posedge clk_i) was_rst_q <= rst_i;

    always @(negedge clk_i) begin
        if (was_rst_q) begin
            // R1
            reset_clear_chk: assert (!valid_o && ctrl_o == '0 && upc_i == '0);
        end
    end

    // R3
    issue_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (upc_i == UAW'($past(upc_i) + 1'b1)));

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> (ctrl_o == '0));

    // R11
    range_redirect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(upc_i) >= UDEPTH_P) |=> (!valid_o && upc_i == '0));

    for (genvar g = 0; g < NG4; g++) begin : g_w
        // R8
        wide_group_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            valid_o |-> $onehot0(ctrl_o[g*S4 +: S4]));
    end

    for (genvar h = 0; h < NG3; h++) begin : g_n
        // R8
        narrow_group_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            valid_o |-> $onehot0(ctrl_o[S3_BASE + h*S3 +: S3]));
    end
endmodule

bind nano_ctrl_store nano_ctrl_store_chk #(.UDEPTH_P(UDEPTH_P)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .valid_o (valid_o),
    .ctrl_o  (ctrl_o),
    .upc_i   (state_q.upc)
);

// File: tb/nano_ctrl_store_tb_top.sv
module nano_ctrl_store_tb_top;
    import nano_cs_pkg::*;

    localparam int CLK_P = 10;
    localparam int VEC_N = 15;

    // per step: condition flag driven, expected valid, expected nanoword index
    localparam int V_COND  [VEC_N] = '{0,0,0,0,1,0,0,1,0,1,0,0,1,0,0};
    localparam int V_VALID [VEC_N] = '{1,1,1,0,1,0,1,1,1,0,1,1,0,0,1};
    localparam int V_IDX   [VEC_N] = '{1,2,1,0,3,0,1,2,1,0,4,20,0,0,1};

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic cond_i = 1'b0;
    logic [NSIG-1:0] ctrl_o;
    logic valid_o;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    nano_ctrl_store dut_i (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .cond_i  (cond_i),
        .ctrl_o  (ctrl_o),
        .valid_o (valid_o)
    );

    function automatic string row_tag(int i);
        case (i)
            0, 1:    return "R3";
            2, 8:    return "R9";
            3:       return "R2";
            4, 7:    return "R7";
            5, 6, 12: return "R5";
            9, 10:   return "R6";
            11:      return "R10";
            default: return "R11";
        endcase
    endfunction

    // Expected control vector, decoded per the field layout of R8
    function automatic logic [NSIG-1:0] exp_ctrl(int v, int idx);
        logic [NSIG-1:0] e;
        logic [NWW-1:0]  w;
        int code;
        e = '0;
        if (v == 0 || idx >= NDEPTH) return e;
        w = nano_word(idx);
        for (int g = 0; g < NG4; g++) begin
            code = int'(w[g*F4 +: F4]);
            if (code != 0) e[g*S4 + code - 1] = 1'b1;
        end
        for (int h = 0; h < NG3; h++) begin
            code = int'(w[G3_BASE + h*F3 +: F3]);
            if (code != 0) e[S3_BASE + h*S3 + code - 1] = 1'b1;
        end
        for (int d = 0; d < ND; d++) e[SD_BASE + d] = w[DIR_BASE + d];
        return e;
    endfunction

    task automatic check_vec(string tag, logic [NSIG-1:0] act, logic [NSIG-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s ctrl act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s valid act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 2000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_bit("R1", valid_o, 1'b0);
        check_vec("R1", ctrl_o, '0);
        rst_i = 1'b0;

        for (int i = 0; i < VEC_N; i++) begin
            cond_i = V_COND[i][0];
            tick();
            check_bit(row_tag(i), valid_o, V_VALID[i][0]);
            // R4: branch steps must show an all-zero vector
            check_vec((V_VALID[i] != 0) ? row_tag(i) : "R4",
                      ctrl_o, exp_ctrl(V_VALID[i], V_IDX[i]));
            if (i == 0) begin
                // R8: index 1 puts code 1 in wide group 0 and code 3 in narrow group 0
                check_vec("R8", {{(NSIG-2){1'b0}}, ctrl_o[1:0]}, {{(NSIG-2){1'b0}}, 2'b01});
                check_vec("R8", {{(NSIG-S3){1'b0}}, ctrl_o[S3_BASE +: S3]},
                          {{(NSIG-S3){1'b0}}, 7'b0000100});
            end
        end

        // R1: reset in mid-run clears outputs and restarts at address 0
        cond_i = 1'b0;
        tick();
        rst_i = 1'b1;
        tick();
        check_bit("R1", valid_o, 1'b0);
        check_vec("R1", ctrl_o, '0);
        rst_i = 1'b0;
        tick();
        check_bit("R1", valid_o, 1'b1);
        check_vec("R1", ctrl_o, exp_ctrl(1, 1));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule